// File: doc/BRIEF.md
# Serial Configuration EEPROM Auto-Loader

This block fills a chip's configuration store from a small 3-wire serial EEPROM with byte-wide words and nine address bits, so 256-byte and 512-byte parts both fit. It drives chip select, serial clock and serial data toward the memory and samples the memory's data line. Each byte comes from its own read command. The serial clock runs at a programmable fraction of the system clock.

The first byte read is always address 0. The contents count as valid only when that byte holds the signature 0xA5. If the signature is correct, the block reads the regions that the reset cause asks for:
- MAC address bytes.
- A short Ethernet parameter area.
- The hub parameter area at 0x20..0x39.

If the signature is wrong, the requested regions go back to their hardware defaults.

A busy flag stays high from reset until loading ends, and the host interface uses it to refuse transactions. A valid flag reports that a complete, signed image was loaded. The first load, after the asynchronous reset is released, is a full load. Later loads are started by a start pulse that carries a reset cause.

Top module: `eeprom_autoload`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first load ends, `busy_o` is 1, `valid_o` is 0, `ee_cs_o` is 0 and every configuration output holds its default. The first load after reset release is a full load without any start pulse.
- R2: Each read command is framed as follows:
  - `ee_cs_o` is high for the whole command.
  - `ee_do_o` presents twelve bits, most significant first, stable at each rising `ee_sclk_o`: 1, 1, 0, then address bits 8 down to 0.
  - After the memory's dummy zero, eight data bits are taken most significant first on the falling clock edges of clocks 13 to 20.
- R3: `ee_sclk_o` idles low whenever `ee_cs_o` is low. Inside a command, every high phase and every low phase lasts exactly `SCLK_HALF` system clocks.
- R4: Between two read commands, `ee_cs_o` stays low for at least 2*`SCLK_HALF` system clocks.
- R5: Every load starts by reading address 0. Further reads follow only if that byte equals 0xA5.
- R6: With a wrong signature, a load performs exactly one read and ends with `valid_o` 0. It returns every region requested by the cause to its default, and it leaves the other regions unchanged.
- R7: `mac_o` takes byte 0x01 in bits [7:0] and so on up to byte 0x06 in bits [47:40].
- R8: Cause 2'b00 (full) reads 0x01..`ETH_LAST` and then `HUB_FIRST`..`HUB_LAST`, in ascending order. It updates `mac_o`, `eth_cfg_o` (byte 0x07 in bits [7:0]) and `hub_cfg_o` (byte `HUB_FIRST` in bits [7:0]).
- R9: Cause 2'b01 (bus reset) reads only 0x01..0x06. Only `mac_o` may change.
- R10: Cause 2'b10 and cause 2'b11 (software reset or reload command) read 0x01..`ETH_LAST`. `hub_cfg_o` is left unchanged.
- R11: `valid_o` clears when a load starts. It rises in the same cycle that `busy_o` falls, and only when the signature matched and every requested byte was read.
- R12: A start pulse that arrives while `busy_o` is 1 is ignored.
- R13: Configuration outputs change only during a load. While `busy_o` is 0 and no start arrives, the serial lines stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| start_i | input | 1 | Launch a load with cause `cause_i` |
| cause_i | input | 2 | Reset cause: 00 full, 01 MAC only, 10/11 Ethernet area |
| busy_o | output | 1 | Load in progress; host transactions refused |
| valid_o | output | 1 | Signed image fully loaded |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sclk_o | output | 1 | EEPROM serial clock |
| ee_do_o | output | 1 | Command and address toward the EEPROM |
| ee_di_i | input | 1 | Data from the EEPROM |
| mac_o | output | 48 | MAC address |
| eth_cfg_o | output | 8*(ETH_LAST-6) (16) | Ethernet parameter bytes 0x07..ETH_LAST |
| hub_cfg_o | output | 8*(HUB_LAST-HUB_FIRST+1) (208) | Hub parameter bytes |

## Verification
A sequencer stuck in the wrong region, or a bad next-address step, shows up in the order of addresses on `ee_do_o` within the next command, roughly 40 serial half-periods after the faulty state appears. A divider or framing error breaks the clock-phase and gap widths on the first command it touches. A signature or cause decode error is visible only when the load ends: a region that should have kept its contents changes, or a default fails to return, and `valid_o` ends with the wrong value. The bench therefore sweeps every cause with good and bad signatures, using distinct memory patterns, so that a stale byte never matches the expected byte by chance.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  typedef enum logic [1:0] {
    CAUSE_FULL = 2'b00,
    CAUSE_MAC  = 2'b01,
    CAUSE_ETH  = 2'b10,
    CAUSE_ETH2 = 2'b11
  } eeld_cause_e;

  localparam int unsigned AW         = 9;
  localparam int unsigned HDR_W      = 3;
  localparam logic [2:0]  RD_HDR     = 3'b110;
  localparam int unsigned CMD_W      = HDR_W + AW;      // 12
  localparam int unsigned FRAME_LEN  = CMD_W + 8;       // 20 clocks
  localparam int unsigned MAC_FIRST  = 1;
  localparam int unsigned MAC_LAST   = 6;
endpackage

// File: rtl/eeld_clkdiv.sv
module eeld_clkdiv #(
  parameter int unsigned HALF = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eeld_xfer.sv
module eeld_xfer
  import eeld_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          idle_o,
  output logic          run_o,
  output logic          cs_o,
  output logic          sclk_o,
  output logic          do_o,
  input  logic          di_i,
  output logic          vld_o,
  output logic [7:0]    data_o
);
  typedef enum logic [1:0] {X_IDLE, X_SHIFT, X_GAP} xst_e;

  xst_e             st_q;
  logic [4:0]       bit_q;
  logic             hi_q, gap_q, vld_q;
  logic [CMD_W-1:0] cmd_q;
  logic [7:0]       sh_q, data_q;

  localparam logic [4:0] DATA_FIRST = 5'(CMD_W);
  localparam logic [4:0] LAST_BIT   = 5'(FRAME_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= X_IDLE; bit_q <= '0; hi_q <= 1'b0; gap_q <= 1'b0;
      cmd_q <= '0; sh_q <= '0; data_q <= '0; vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        X_IDLE: if (req_i) begin
          cmd_q <= {RD_HDR, addr_i};
          bit_q <= '0;
          hi_q  <= 1'b0;
          st_q  <= X_SHIFT;
        end
        X_SHIFT: if (tick_i) begin
          if (!hi_q) hi_q <= 1'b1;
          else begin
            hi_q  <= 1'b0;
            cmd_q <= cmd_q << 1;
            if (bit_q >= DATA_FIRST) sh_q <= {sh_q[6:0], di_i};
            if (bit_q == LAST_BIT) begin
              data_q <= {sh_q[6:0], di_i};
              vld_q  <= 1'b1;
              gap_q  <= 1'b0;
              st_q   <= X_GAP;
            end else bit_q <= bit_q + 1'b1;
          end
        end
        X_GAP: if (tick_i) begin
          if (gap_q) st_q <= X_IDLE;
          else       gap_q <= 1'b1;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == X_IDLE);
  assign run_o  = !idle_o;
  assign cs_o   = (st_q == X_SHIFT);
  assign sclk_o = hi_q;
  assign do_o   = cs_o & cmd_q[CMD_W-1];
  assign vld_o  = vld_q;
  assign data_o = data_q;
endmodule

// File: rtl/eeld_cfg_byte.sv
module eeld_cfg_byte #(
  parameter int unsigned ADDR = 1,
  parameter logic [7:0]  DEF  = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [8:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic       restore_i,
  output logic [7:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 q_o <= DEF;
    else if (restore_i)                          q_o <= DEF;
    else if (we_i && (waddr_i == 9'(ADDR)))      q_o <= wdata_i;
  end
endmodule

// File: rtl/eeld_store.sv
module eeld_store #(
  parameter int unsigned ETH_LAST  = 8,
  parameter int unsigned HUB_FIRST = 32,
  parameter int unsigned HUB_LAST  = 57,
  parameter logic [47:0] MAC_DEF   = 48'h0,
  parameter logic [8*(ETH_LAST-6)-1:0] ETH_DEF = '0,
  parameter logic [8*(HUB_LAST-HUB_FIRST+1)-1:0] HUB_DEF = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [8:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic       rst_mac_i,
  input  logic       rst_eth_i,
  input  logic       rst_hub_i,
  output logic [47:0] mac_o,
  output logic [8*(ETH_LAST-6)-1:0] eth_o,
  output logic [8*(HUB_LAST-HUB_FIRST+1)-1:0] hub_o
);
  localparam int unsigned ETH_N = ETH_LAST - 6;
  localparam int unsigned HUB_N = HUB_LAST - HUB_FIRST + 1;

  for (genvar i = 0; i < 6; i++) begin : g_mac
    eeld_cfg_byte #(.ADDR(1 + i), .DEF(MAC_DEF[8*i +: 8])) u_b (
      .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i,
      .restore_i(rst_mac_i), .q_o(mac_o[8*i +: 8]));
  end
  for (genvar i = 0; i < ETH_N; i++) begin : g_eth
    eeld_cfg_byte #(.ADDR(7 + i), .DEF(ETH_DEF[8*i +: 8])) u_b (
      .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i,
      .restore_i(rst_eth_i), .q_o(eth_o[8*i +: 8]));
  end
  for (genvar i = 0; i < HUB_N; i++) begin : g_hub
    eeld_cfg_byte #(.ADDR(HUB_FIRST + i), .DEF(HUB_DEF[8*i +: 8])) u_b (
      .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i,
      .restore_i(rst_hub_i), .q_o(hub_o[8*i +: 8]));
  end
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
  import eeld_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 63,
  parameter int unsigned ETH_LAST  = 8,
  parameter int unsigned HUB_FIRST = 32,
  parameter int unsigned HUB_LAST  = 57,
  parameter logic [7:0]  SIGNATURE = 8'hA5,
  parameter logic [47:0] MAC_DEF   = 48'h0,
  parameter logic [8*(ETH_LAST-6)-1:0] ETH_DEF = '0,
  parameter logic [8*(HUB_LAST-HUB_FIRST+1)-1:0] HUB_DEF = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  cause_i,
  output logic        busy_o,
  output logic        valid_o,
  output logic        ee_cs_o,
  output logic        ee_sclk_o,
  output logic        ee_do_o,
  input  logic        ee_di_i,
  output logic [47:0] mac_o,
  output logic [8*(ETH_LAST-6)-1:0] eth_cfg_o,
  output logic [8*(HUB_LAST-HUB_FIRST+1)-1:0] hub_cfg_o
);
  localparam logic [AW-1:0] A_MAC_END = AW'(MAC_LAST);
  localparam logic [AW-1:0] A_ETH_END = AW'(ETH_LAST);
  localparam logic [AW-1:0] A_HUB_BEG = AW'(HUB_FIRST);
  localparam logic [AW-1:0] A_HUB_END = AW'(HUB_LAST);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_e;

  sq_e         sq_q;
  eeld_cause_e cause_q;
  logic [AW-1:0] addr_q, addr_nxt, region_end;
  logic        sig_q, valid_q, is_last;
  logic        tick, xf_idle, xf_run, rd_vld, req;
  logic [7:0]  rd_data;
  logic        sig_bad, we;

  eeld_clkdiv #(.HALF(SCLK_HALF)) u_div (
    .clk_i, .rst_ni, .run_i(xf_run), .tick_o(tick));

  eeld_xfer u_xfer (
    .clk_i, .rst_ni, .tick_i(tick), .req_i(req), .addr_i(addr_q),
    .idle_o(xf_idle), .run_o(xf_run), .cs_o(ee_cs_o), .sclk_o(ee_sclk_o),
    .do_o(ee_do_o), .di_i(ee_di_i), .vld_o(rd_vld), .data_o(rd_data));

  assign req        = (sq_q == SQ_ISSUE) && xf_idle;
  assign region_end = (cause_q == CAUSE_MAC) ? A_MAC_END : A_ETH_END;
  assign is_last    = (cause_q == CAUSE_FULL) ? (addr_q == A_HUB_END) : (addr_q == region_end);
  assign addr_nxt   = ((cause_q == CAUSE_FULL) && (addr_q == A_ETH_END)) ? A_HUB_BEG : addr_q + 1'b1;
  assign sig_bad    = rd_vld && sig_q && (rd_data != SIGNATURE);
  assign we         = rd_vld && !sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q <= SQ_ISSUE; cause_q <= CAUSE_FULL; addr_q <= '0;
      sig_q <= 1'b1; valid_q <= 1'b0;
    end else begin
      unique case (sq_q)
        SQ_IDLE: if (start_i) begin
          cause_q <= eeld_cause_e'(cause_i);
          addr_q  <= '0;
          sig_q   <= 1'b1;
          valid_q <= 1'b0;
          sq_q    <= SQ_ISSUE;
        end
        SQ_ISSUE: if (xf_idle) sq_q <= SQ_WAIT;
        SQ_WAIT: if (rd_vld) begin
          if (sig_q) begin
            if (rd_data == SIGNATURE) begin
              sig_q  <= 1'b0;
              addr_q <= AW'(MAC_FIRST);
              sq_q   <= SQ_ISSUE;
            end else sq_q <= SQ_IDLE;
          end else if (is_last) begin
            valid_q <= 1'b1;
            sq_q    <= SQ_IDLE;
          end else begin
            addr_q <= addr_nxt;
            sq_q   <= SQ_ISSUE;
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  eeld_store #(
    .ETH_LAST(ETH_LAST), .HUB_FIRST(HUB_FIRST), .HUB_LAST(HUB_LAST),
    .MAC_DEF(MAC_DEF), .ETH_DEF(ETH_DEF), .HUB_DEF(HUB_DEF)
  ) u_store (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(addr_q), .wdata_i(rd_data),
    .rst_mac_i(sig_bad),
    .rst_eth_i(sig_bad && (cause_q != CAUSE_MAC)),
    .rst_hub_i(sig_bad && (cause_q == CAUSE_FULL)),
    .mac_o(mac_o), .eth_o(eth_cfg_o), .hub_o(hub_cfg_o));

  assign busy_o  = (sq_q != SQ_IDLE);
  assign valid_o = valid_q;
endmodule

// File: rtl/eeld_chk.sv
module eeld_chk #(
  parameter int unsigned SCLK_HALF = 63,
  parameter int unsigned ETH_W = 16,
  parameter int unsigned HUB_W = 208
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             valid_o,
  input logic             ee_cs_o,
  input logic             ee_sclk_o,
  input logic [47:0]      mac_o,
  input logic [ETH_W-1:0] eth_cfg_o,
  input logic [HUB_W-1:0] hub_cfg_o
);
  logic        sclk_prev_q;
  logic [15:0] sclk_run_q, cs_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0; sclk_run_q <= '1; cs_low_q <= '1;
    end else begin
      sclk_prev_q <= ee_sclk_o;
      if (ee_sclk_o != sclk_prev_q)  sclk_run_q <= 16'd1;
      else if (sclk_run_q != '1)     sclk_run_q <= sclk_run_q + 1'b1;
      if (ee_cs_o)                   cs_low_q <= '0;
      else if (cs_low_q != '1)       cs_low_q <= cs_low_q + 1'b1;
    end
  end

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> !ee_sclk_o);
  // R3
  sclk_phase_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sclk_o != sclk_prev_q) |-> ({16'd0, sclk_run_q} >= 32'(SCLK_HALF)));
  // R4
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_cs_o) |-> ({16'd0, cs_low_q} >= 32'(2 * SCLK_HALF)));
  // R11
  valid_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  // R11
  valid_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $fell(busy_o));
  // R13
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> ($stable(mac_o) && $stable(eth_cfg_o) && $stable(hub_cfg_o)));
  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !ee_cs_o);
endmodule

bind eeprom_autoload eeld_chk #(
  .SCLK_HALF(SCLK_HALF), .ETH_W(8*(ETH_LAST-6)), .HUB_W(8*(HUB_LAST-HUB_FIRST+1))
) u_eeld_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .valid_o(valid_o),
  .ee_cs_o(ee_cs_o), .ee_sclk_o(ee_sclk_o), .mac_o(mac_o),
  .eth_cfg_o(eth_cfg_o), .hub_cfg_o(hub_cfg_o));

// File: tb/eeprom_autoload_bench.sv
module eeprom_autoload_bench;
  localparam int HALF = 2;
  localparam int ETH_LAST = 8;
  localparam int HUB_F = 32;
  localparam int HUB_L = 57;
  localparam int ETH_W = 8 * (ETH_LAST - 6);
  localparam int HUB_W = 8 * (HUB_L - HUB_F + 1);
  localparam logic [47:0] MAC_D = 48'h02_00_5E_10_20_31;
  localparam logic [ETH_W-1:0] ETH_D = 16'h0418;
  localparam logic [HUB_W-1:0] HUB_D = {13{16'hC33C}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] cause = 2'b00;
  logic busy, valid, cs, sclk, dout, din;
  logic [47:0] mac;
  logic [ETH_W-1:0] eth;
  logic [HUB_W-1:0] hub;

  always #2 clk = ~clk;

  eeprom_autoload #(
    .SCLK_HALF(HALF), .ETH_LAST(ETH_LAST), .HUB_FIRST(HUB_F), .HUB_LAST(HUB_L),
    .MAC_DEF(MAC_D), .ETH_DEF(ETH_D), .HUB_DEF(HUB_D)
  ) u_eeprom_autoload (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cause_i(cause),
    .busy_o(busy), .valid_o(valid), .ee_cs_o(cs), .ee_sclk_o(sclk),
    .ee_do_o(dout), .ee_di_i(din), .mac_o(mac), .eth_cfg_o(eth), .hub_cfg_o(hub));

  int n_chk = 0, n_err = 0;
  logic [7:0] mem [512];
  int addr_log [64];
  int log_n = 0, hdr_bad = 0;
  logic [47:0] exp_mac = MAC_D;
  logic [ETH_W-1:0] exp_eth = ETH_D;
  logic [HUB_W-1:0] exp_hub = HUB_D;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // EEPROM model: captures command on rising clocks, drives data after them
  int nrise = 0, ee_addr = 0;
  logic [11:0] cmd_sh = '0;
  initial din = 1'b0;
  always @(posedge sclk or negedge cs) begin
    if (!cs) nrise = 0;
    else begin
      nrise++;
      if (nrise <= 12) cmd_sh = {cmd_sh[10:0], dout};
      if (nrise == 12) begin
        if (cmd_sh[11:9] != 3'b110) hdr_bad++;
        ee_addr = int'(cmd_sh[8:0]);
        if (log_n < 64) addr_log[log_n] = ee_addr;
        log_n++;
        din <= 1'b0;
      end else if (nrise >= 13 && nrise <= 20) din <= mem[ee_addr][20 - nrise];
    end
  end

  // serial timing monitor
  logic prev_cs = 1'b0, prev_sclk = 1'b0, seen_fall = 1'b0;
  int run = 0, low_run = 0, min_run = 1000000, max_run = 0, min_gap = 1000000, idle_err = 0;
  always @(negedge clk) begin
    if (!cs && sclk) idle_err++;
    if (cs && !prev_cs) begin
      if (seen_fall && low_run < min_gap) min_gap = low_run;
      run = 1;
    end else if (cs) begin
      if (sclk != prev_sclk) begin
        if (run < min_run) min_run = run;
        if (run > max_run) max_run = run;
        run = 1;
      end else run++;
    end else if (prev_cs) begin
      if (run < min_run) min_run = run;
      if (run > max_run) max_run = run;
    end
    if (!cs && prev_cs) seen_fall = 1'b1;
    low_run = cs ? 0 : low_run + 1;
    prev_cs = cs;
    prev_sclk = sclk;
  end

  task automatic fill_mem(input int pat, input bit good);
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * 7 + pat * 29 + 3) & 255);
    mem[0] = good ? 8'hA5 : 8'h5A;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!busy, "R1 load never ended", 256'(busy), 256'(0));
  endtask

  task automatic verify(input int cause_v, input bit good);
    int exp_n;
    int exp_list [64];
    int bad;
    exp_n = 0;
    exp_list[exp_n++] = 0;
    if (good) begin
      for (int a = 1; a <= ((cause_v == 1) ? 6 : ETH_LAST); a++) exp_list[exp_n++] = a;
      if (cause_v == 0) for (int a = HUB_F; a <= HUB_L; a++) exp_list[exp_n++] = a;
      for (int i = 0; i < 6; i++) exp_mac[8*i +: 8] = mem[1 + i];
      if (cause_v != 1) for (int i = 0; i < ETH_W / 8; i++) exp_eth[8*i +: 8] = mem[7 + i];
      if (cause_v == 0) for (int i = 0; i < HUB_W / 8; i++) exp_hub[8*i +: 8] = mem[HUB_F + i];
    end else begin
      exp_mac = MAC_D;
      if (cause_v != 1) exp_eth = ETH_D;
      if (cause_v == 0) exp_hub = HUB_D;
    end
    bad = 0;
    for (int i = 0; i < exp_n && i < log_n; i++) if (addr_log[i] != exp_list[i]) bad++;
    chk(log_n == exp_n, good ? "R5/R8/R9/R10 read count" : "R6 read count", 256'(log_n), 256'(exp_n));
    chk(bad == 0, "R5 address order", 256'(bad), 256'(0));
    chk(hdr_bad == 0, "R2 command header", 256'(hdr_bad), 256'(0));
    chk(mac == exp_mac, good ? "R7 mac byte order" : "R6 mac default", 256'(mac), 256'(exp_mac));
    chk(eth == exp_eth, (cause_v == 1) ? "R9 eth untouched" : "R10 eth area", 256'(eth), 256'(exp_eth));
    chk(hub == exp_hub, (cause_v == 0) ? "R8 hub area" : "R10 hub untouched", 256'(hub), 256'(exp_hub));
    chk(valid == good, good ? "R11 valid after load" : "R6 valid low", 256'(valid), 256'(good));
  endtask

  task automatic do_load(input int cause_v, input int pat, input bit good);
    fill_mem(pat, good);
    log_n = 0; hdr_bad = 0;
    @(negedge clk); start = 1'b1; cause = 2'(cause_v);
    @(negedge clk); start = 1'b0;
    chk(busy && !valid, "R11 valid cleared at start", {254'd0, busy, valid}, 256'd2);
    wait_idle();
    verify(cause_v, good);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    fill_mem(0, 1'b1);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy && !valid && !cs, "R1 reset flags", {253'd0, busy, valid, cs}, 256'd4);
    chk(mac == MAC_D && eth == ETH_D && hub == HUB_D, "R1 reset defaults", 256'(mac), 256'(MAC_D));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, "R1 busy after release", 256'(busy), 256'(1));
    wait_idle();
    verify(0, 1'b1);

    // sweep causes with good signature
    for (int c = 0; c < 4; c++) do_load(c, c + 1, 1'b1);
    // bad signature per cause, then restore
    do_load(1, 9, 1'b0);
    do_load(0, 10, 1'b1);
    do_load(2, 11, 1'b0);
    do_load(0, 12, 1'b1);
    do_load(0, 13, 1'b0);
    do_load(3, 14, 1'b1);

    // R12: start while busy ignored
    fill_mem(15, 1'b1);
    log_n = 0; hdr_bad = 0;
    @(negedge clk); start = 1'b1; cause = 2'b01;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; cause = 2'b00;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk(log_n == 7, "R12 second start ignored", 256'(log_n), 256'(7));
    verify(1, 1'b1);

    // R13: idle stays quiet and stable
    fill_mem(16, 1'b1);
    log_n = 0;
    repeat (500) @(negedge clk);
    chk(log_n == 0, "R13 no reads while idle", 256'(log_n), 256'(0));
    chk(mac == exp_mac && eth == exp_eth && hub == exp_hub, "R13 outputs hold", 256'(mac), 256'(exp_mac));

    chk(min_run == HALF && max_run == HALF, "R3 phase width", 256'(min_run), 256'(HALF));
    chk(idle_err == 0, "R3 sclk idle low", 256'(idle_err), 256'(0));
    chk(min_gap >= 2 * HALF, "R4 chip select gap", 256'(min_gap), 256'(2 * HALF));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule